// File: doc/BRIEF.md
# CAN Transmit Fault Supervisor

This block guards the transmit path of a CAN transceiver. It watches the transmit data input from the protocol controller (`txd_i`, 0 = dominant) and the output of the differential bus receiver (`rxd_i`, 0 = dominant). It also takes a one-cycle host request to enter Normal mode. Two faults are detected. The first is a transmit line held dominant for too long. The second is a receiver that stays recessive while the block is itself driving dominant. Either fault turns the bus driver off, so the bus falls back to recessive, and sets a sticky flag.

The two faults recover differently. After a dominant timeout, the driver returns on a Normal-mode request. It also returns when the receiver goes from recessive to dominant while the transmit input is recessive. This suits a transmit pin shorted to the receive pin: each incoming dominant bit locks the bus again and trips the timeout again. After a stuck-recessive receiver fault, the driver stays off until the receiver output has changed at least once and the host then requests Normal mode.

Both line inputs pass through a two-stage synchroniser. The timeout and the receiver window are counted in clock cycles. The request and clear pins are taken to be synchronous to `clk`. The block has no data stream, so all pins are plain level or pulse signals.

Top module: `can_tx_supervisor`

## Requirements
- R1: When the synchronised transmit input stays 0 for `TXD_TMO` consecutive cycles, `drv_en_o` goes to 0 and `bus_tx_o` is held at 1 for as long as the driver is off.
- R2: A transmit timeout sets `txd_stuck_flag_o`. The flag then stays at 1 across any later recovery until it is cleared.
- R3: After a transmit timeout, a one-cycle `mode_normal_i` pulse turns the driver back on in the following cycle, even while `txd_i` is still 0.
- R4: After a transmit timeout, a receiver change from 1 to 0 while the transmit input is 1 turns the driver back on. Receiver toggling while the transmit input is 0 has no effect.
- R5: After any recovery the timeout count restarts, so a transmit input that stays at 0 (for example because it is shorted to the receiver) trips again after another `TXD_TMO` cycles.
- R6: While the driver is on and driving 0, if the receiver output stays at 1 for `RXD_WIN` of those cycles, `drv_en_o` goes to 0 and `rxd_stuck_flag_o` is set.
- R7: A receiver fault clears only when the receiver output has changed at least once and `mode_normal_i` is pulsed afterwards. A `mode_normal_i` pulse with no prior receiver change leaves the driver off.
- R8: `clr_txd_flag_i` and `clr_rxd_flag_i` each clear their own flag. Clearing a flag does not turn the driver back on.
- R9: While `rst_n` is 0, `drv_en_o` is 0, both flags are 0 and `bus_tx_o` is 1. The driver comes on in the first cycle after reset is released.
- R10: While the driver is on, `bus_tx_o` follows `txd_i` two clock cycles later, which is the latency of the synchroniser.
- R11: A single recessive cycle on the transmit input restarts the timeout count, so two dominant stretches that are each shorter than `TXD_TMO` do not trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_i | input | 1 | Transmit data from the protocol controller, 0 = dominant |
| rxd_i | input | 1 | Differential receiver output, 0 = dominant |
| mode_normal_i | input | 1 | One-cycle host request to enter Normal mode |
| clr_txd_flag_i | input | 1 | Clears the transmit-timeout flag |
| clr_rxd_flag_i | input | 1 | Clears the receiver-stuck flag |
| drv_en_o | output | 1 | Bus driver enable |
| bus_tx_o | output | 1 | Level presented to the bus driver, 1 when disabled |
| txd_stuck_flag_o | output | 1 | Sticky transmit-timeout flag |
| rxd_stuck_flag_o | output | 1 | Sticky receiver-stuck flag |

## Verification
The assertions take `mode_normal_i` and the two clear inputs to be synchronous single-cycle pulses. They also take `TXD_TMO` and `RXD_WIN` to be at least 2. The bench drives every input on the falling clock edge, so the pins are always stable around the sampling edge. It holds each line level for many cycles, which keeps the synchroniser free of metastability and keeps every hold and recovery property inside the stated request protocol.

// File: rtl/can_sup_pkg.sv
package can_sup_pkg;

  // one cycle of a watchdog: detection and clearing events
  typedef struct packed {
    logic trip;
    logic recover;
  } wd_evt_t;

  localparam logic LVL_DOM = 1'b0;
  localparam logic LVL_REC = 1'b1;

endpackage

// File: rtl/can_sup_sync.sv
module can_sup_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2,
  parameter logic RST_LVL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  stg_q[g] <= {W{RST_LVL}};
        else if (g == 0) stg_q[g] <= d_i;
        else         stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/can_sup_txd_wd.sv
module can_sup_txd_wd
  import can_sup_pkg::*;
#(
  parameter int TXD_TMO = 65536
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    txd_s,
  input  logic    rxd_fall,
  input  logic    nreq,
  output logic    fault_o,
  output wd_evt_t evt_o
);

  localparam int TW = $clog2(TXD_TMO + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TXD_TMO - 1);
  localparam logic [TW-1:0] T_MAX  = TW'(TXD_TMO);

  logic [TW-1:0] cnt_q;
  logic          fault_q;
  wd_evt_t       evt;

  always_comb begin
    evt.recover = fault_q & (nreq | ((txd_s == LVL_REC) & rxd_fall));
    evt.trip    = ~fault_q & (txd_s == LVL_DOM) & (cnt_q == T_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if ((txd_s == LVL_REC) || evt.recover) begin
      cnt_q <= '0;
    end else if (cnt_q != T_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            fault_q <= 1'b0;
    else if (evt.trip)     fault_q <= 1'b1;
    else if (evt.recover)  fault_q <= 1'b0;
  end

  assign fault_o = fault_q;
  assign evt_o   = evt;

  AST_TCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= T_MAX); // R1
  AST_TXD_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q && !nreq && !(txd_s && rxd_fall) |=> fault_q); // R4
  AST_TXD_NREQ_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q && nreq |=> !fault_q); // R3

endmodule

// File: rtl/can_sup_rxd_wd.sv
module can_sup_rxd_wd
  import can_sup_pkg::*;
#(
  parameter int RXD_WIN = 256
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    txd_s,
  input  logic    rxd_s,
  input  logic    rxd_prev,
  input  logic    drv_en,
  input  logic    nreq,
  output logic    fault_o,
  output wd_evt_t evt_o
);

  localparam int RW = $clog2(RXD_WIN + 1);
  localparam logic [RW-1:0] W_LAST = RW'(RXD_WIN - 1);
  localparam logic [RW-1:0] W_MAX  = RW'(RXD_WIN);

  logic [RW-1:0] cnt_q;
  logic          fault_q;
  logic          seen_q;
  logic          driving;
  wd_evt_t       evt;

  always_comb begin
    driving     = drv_en & (txd_s == LVL_DOM);
    evt.recover = fault_q & seen_q & nreq;
    evt.trip    = ~fault_q & (rxd_s == LVL_REC) & driving & (cnt_q == W_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if ((rxd_s == LVL_DOM) || evt.recover) begin
      cnt_q <= '0;
    end else if (driving && (cnt_q != W_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 seen_q <= 1'b0;
    else if (!fault_q)          seen_q <= 1'b0;
    else if (rxd_s != rxd_prev) seen_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           fault_q <= 1'b0;
    else if (evt.trip)    fault_q <= 1'b1;
    else if (evt.recover) fault_q <= 1'b0;
  end

  assign fault_o = fault_q;
  assign evt_o   = evt;

  AST_RXD_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q && !seen_q |=> fault_q); // R7
  AST_RCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= W_MAX); // R6

endmodule

// File: rtl/can_sup_flag.sv
module can_sup_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr_i |=> flag_q); // R2
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !set_i |=> !flag_q); // R8

endmodule

// File: rtl/can_tx_supervisor.sv
module can_tx_supervisor
  import can_sup_pkg::*;
#(
  parameter int TXD_TMO     = 65536,
  parameter int RXD_WIN     = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_i,
  input  logic rxd_i,
  input  logic mode_normal_i,
  input  logic clr_txd_flag_i,
  input  logic clr_rxd_flag_i,
  output logic drv_en_o,
  output logic bus_tx_o,
  output logic txd_stuck_flag_o,
  output logic rxd_stuck_flag_o
);

  localparam int NFLAG = 2;

  logic [1:0] sync_q;
  logic       txd_s, rxd_s, rxd_prev_q, rxd_fall;
  logic       run_q;
  logic       txd_fault, rxd_fault;
  wd_evt_t    txd_evt, rxd_evt;
  logic [NFLAG-1:0] flag_set, flag_clr, flag_val;

  can_sup_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_LVL(LVL_REC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({rxd_i, txd_i}), .q_o(sync_q)
  );

  assign txd_s = sync_q[0];
  assign rxd_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_prev_q <= LVL_REC;
      run_q      <= 1'b0;
    end else begin
      rxd_prev_q <= rxd_s;
      run_q      <= 1'b1;
    end
  end

  assign rxd_fall = (rxd_prev_q == LVL_REC) & (rxd_s == LVL_DOM);

  can_sup_txd_wd #(.TXD_TMO(TXD_TMO)) u_txd_wd (
    .clk(clk), .rst_n(rst_n), .txd_s(txd_s), .rxd_fall(rxd_fall),
    .nreq(mode_normal_i), .fault_o(txd_fault), .evt_o(txd_evt)
  );

  can_sup_rxd_wd #(.RXD_WIN(RXD_WIN)) u_rxd_wd (
    .clk(clk), .rst_n(rst_n), .txd_s(txd_s), .rxd_s(rxd_s),
    .rxd_prev(rxd_prev_q), .drv_en(drv_en_o), .nreq(mode_normal_i),
    .fault_o(rxd_fault), .evt_o(rxd_evt)
  );

  assign flag_set = {rxd_evt.trip, txd_evt.trip};
  assign flag_clr = {clr_rxd_flag_i, clr_txd_flag_i};

  genvar f;
  generate
    for (f = 0; f < NFLAG; f++) begin : g_flag
      can_sup_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_i(flag_set[f]), .clr_i(flag_clr[f]),
        .flag_o(flag_val[f])
      );
    end
  endgenerate

  assign txd_stuck_flag_o = flag_val[0];
  assign rxd_stuck_flag_o = flag_val[1];
  assign drv_en_o = run_q & ~txd_fault & ~rxd_fault;
  assign bus_tx_o = drv_en_o ? txd_s : LVL_REC;

  AST_TRIP_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txd_stuck_flag_o) |-> !drv_en_o); // R1
  AST_RXD_TRIP_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxd_stuck_flag_o) |-> !drv_en_o); // R6
  AST_OFF_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en_o |-> bus_tx_o); // R1
  AST_CLR_KEEPS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en_o && run_q && !mode_normal_i && !rxd_fall |=> !drv_en_o); // R8

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_OFF: assert (!drv_en_o && bus_tx_o && !txd_stuck_flag_o && !rxd_stuck_flag_o); // R9
    end
  end

endmodule

// File: tb/tb_can_tx_supervisor.sv
`timescale 1ns/1ps
module tb_can_tx_supervisor;

  localparam int TMO = 20;
  localparam int WIN = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd_i = 1'b1, rxd_i = 1'b1, nreq = 1'b0, clr_t = 1'b0, clr_r = 1'b0;
  logic drv_en_o, bus_tx_o, tflag_o, rflag_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  can_tx_supervisor #(.TXD_TMO(TMO), .RXD_WIN(WIN), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .txd_i(txd_i), .rxd_i(rxd_i),
    .mode_normal_i(nreq), .clr_txd_flag_i(clr_t), .clr_rxd_flag_i(clr_r),
    .drv_en_o(drv_en_o), .bus_tx_o(bus_tx_o),
    .txd_stuck_flag_o(tflag_o), .rxd_stuck_flag_o(rflag_o)
  );

  // behavioural reference: integers for run lengths, shift queues for sync
  logic tq[$] = '{1'b1, 1'b1};
  logic rq[$] = '{1'b1, 1'b1};
  logic m_rprev = 1, m_on = 0, m_tf = 0, m_rf = 0, m_seen = 0, m_tflag = 0, m_rflag = 0;
  int   dom_run = 0, silent_run = 0;

  function automatic logic m_drv();
    return m_on && !m_tf && !m_rf;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tq = '{1'b1, 1'b1}; rq = '{1'b1, 1'b1};
      m_rprev = 1; m_on = 0; m_tf = 0; m_rf = 0; m_seen = 0;
      m_tflag = 0; m_rflag = 0; dom_run = 0; silent_run = 0;
    end else begin
      logic t, r, drv, fall, t_rec, t_hit, r_act, r_rec, r_hit;
      t = tq[1]; r = rq[1]; drv = m_drv();
      fall  = m_rprev && !r;
      t_rec = m_tf && (nreq || (t && fall));
      t_hit = !m_tf && !t && (dom_run == TMO - 1);
      r_act = drv && !t;
      r_rec = m_rf && m_seen && nreq;
      r_hit = !m_rf && r && r_act && (silent_run == WIN - 1);
      if (t || t_rec) dom_run = 0; else if (dom_run < TMO) dom_run++;
      if (!r || r_rec) silent_run = 0; else if (r_act && silent_run < WIN) silent_run++;
      if (!m_rf) m_seen = 0; else if (r != m_rprev) m_seen = 1;
      if (t_hit) m_tf = 1; else if (t_rec) m_tf = 0;
      if (r_hit) m_rf = 1; else if (r_rec) m_rf = 0;
      if (t_hit) m_tflag = 1; else if (clr_t) m_tflag = 0;
      if (r_hit) m_rflag = 1; else if (clr_r) m_rflag = 0;
      m_rprev = r;
      void'(tq.pop_back()); tq.push_front(txd_i);
      void'(rq.pop_back()); rq.push_front(rxd_i);
      m_on = 1;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(drv_en_o, m_drv(), "R3/R4/R7 model drv_en");
      chk(bus_tx_o, m_drv() ? tq[1] : 1'b1, "R10 model bus_tx");
      chk(tflag_o, m_tflag, "R2 model txd flag");
      chk(rflag_o, m_rflag, "R6 model rxd flag");
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_nreq();
    nreq = 1; tick(1); nreq = 0;
  endtask

  initial begin
    tick(3);
    chk(drv_en_o, 1'b0, "R9 reset drv_en");
    chk(bus_tx_o, 1'b1, "R9 reset bus");
    chk(tflag_o, 1'b0, "R9 reset flag");
    rst_n = 1; tick(1);
    chk(drv_en_o, 1'b1, "R9 enabled after reset");
    tick(3);
    // R10 latency
    txd_i = 0; rxd_i = 0; tick(1);
    chk(bus_tx_o, 1'b1, "R10 one edge later");
    tick(1);
    chk(bus_tx_o, 1'b0, "R10 two edges later");
    txd_i = 1; tick(4);
    // R11 short stretches
    txd_i = 0; tick(TMO - 5); txd_i = 1; tick(1); txd_i = 0; tick(TMO - 5);
    chk(drv_en_o, 1'b1, "R11 no trip");
    chk(tflag_o, 1'b0, "R11 no flag");
    // R1/R2 timeout
    tick(10);
    chk(drv_en_o, 1'b0, "R1 driver off");
    chk(bus_tx_o, 1'b1, "R1 bus recessive");
    chk(tflag_o, 1'b1, "R2 flag set");
    // R4 negative: receiver toggles while transmit dominant
    rxd_i = 1; tick(3); rxd_i = 0; tick(4);
    chk(drv_en_o, 1'b0, "R4 edge with txd dominant ignored");
    txd_i = 1; rxd_i = 1; tick(4); rxd_i = 0; tick(4);
    chk(drv_en_o, 1'b1, "R4 recovered on rxd edge");
    chk(tflag_o, 1'b1, "R2 flag sticky after recovery");
    // R5 shorted: dominant again trips again
    txd_i = 0; tick(TMO + 8);
    chk(drv_en_o, 1'b0, "R5 re-trip");
    // R8 clear does not enable
    clr_t = 1; tick(1); clr_t = 0; tick(2);
    chk(tflag_o, 1'b0, "R8 flag cleared");
    chk(drv_en_o, 1'b0, "R8 still off after clear");
    // R3 normal request with txd still dominant
    pulse_nreq();
    chk(drv_en_o, 1'b1, "R3 normal request recovers");
    tick(TMO + 4);
    chk(drv_en_o, 1'b0, "R5 re-trip after normal");
    chk(tflag_o, 1'b1, "R5 flag set again");
    txd_i = 1; tick(3); pulse_nreq(); tick(1);
    chk(drv_en_o, 1'b1, "R3 recovered");
    clr_t = 1; tick(1); clr_t = 0; tick(3);
    // R6 receiver stuck recessive
    txd_i = 0; rxd_i = 1; tick(16); txd_i = 1; tick(3);
    chk(drv_en_o, 1'b0, "R6 driver off");
    chk(rflag_o, 1'b1, "R6 flag set");
    chk(tflag_o, 1'b0, "R6 no txd trip");
    // R7 normal without edge
    pulse_nreq(); tick(2);
    chk(drv_en_o, 1'b0, "R7 no edge no recovery");
    rxd_i = 0; tick(4);
    clr_r = 1; tick(1); clr_r = 0; tick(1);
    chk(rflag_o, 1'b0, "R8 rxd flag cleared");
    chk(drv_en_o, 1'b0, "R8 rxd clear keeps off");
    pulse_nreq();
    chk(drv_en_o, 1'b1, "R7 edge then normal recovers");
    tick(5);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule